// File: doc/BRIEF.md
# Two-dimensional parity corrector

The block protects a word of `ROWS*COLS` data bits, treated as a grid, with even parity over every row, every column and the whole word. Encode mode accepts a data word and returns it unchanged with `ROWS+COLS+1` check bits appended. Decode mode accepts a data word and check bits together and recomputes all of the parities. It repairs any single flipped bit, in the data or in the check bits, and returns a fully consistent word and check vector. It also reports where the repair was made. A word with two flipped bits is passed through untouched and marked uncorrectable.

Words enter and leave through a valid/ready handshake with one output register stage. A word accepted on a clock edge appears on the outputs immediately after that edge. It stays there, stable, until the consumer takes it.

Top module: `tdp_corrector`

## Requirements
- R1: Data bit (r,c) is `data[r*COLS+c]`. In the check vector, bit r (for r < ROWS) is the parity of row r, bit ROWS+c is the parity of column c, and bit ROWS+COLS is the corner, which is the parity of all data bits. That gives ROWS+COLS+1 bits in total.
- R2: When `in_mode`=0 (encode), the output carries the input data and the even-parity check bits of R1, with both flags low and loc, row and col at 0.
- R3: When `in_mode`=1 (decode) and every parity agrees, data and check bits pass through unchanged and both flags stay low.
- R4: A single flipped data bit at (r,c) is inverted back. The output shows corrected=1, loc=0, row=r and col=c.
- R5: A single flipped row check bit r is restored and the data is left unchanged. The output shows corrected=1, loc=1, row=r and col=0.
- R6: A single flipped column check bit c is restored. The output shows corrected=1, loc=2, row=0 and col=c.
- R7: A single flipped corner bit is restored. The output shows corrected=1, loc=3, row=0 and col=0.
- R8: Any two-bit error, and any other pattern that does not match R3 to R7, gives uncorrectable=1 and corrected=0. Data and check bits pass through unchanged, and loc, row and col are 0.
- R9: A word accepted on edge k drives `out_valid` high after edge k. With no new word and `out_ready` high, `out_valid` falls after the next edge.
- R10: `in_ready` is low while an output is held and `out_ready` is low. A held output keeps its value until it is taken.
- R11: After reset, `out_valid` and all outputs are 0 and `in_ready` is 1.
- R12: The corrected and uncorrectable flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_mode | input | 1 | 0 encode, 1 decode |
| in_data | input | ROWS*COLS | Data grid, row-major |
| in_chk | input | ROWS+COLS+1 | Received check bits (decode only) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | ROWS*COLS | Data, corrected in decode |
| out_chk | output | ROWS+COLS+1 | Check bits, generated or repaired |
| out_corrected | output | 1 | One bit was repaired |
| out_uncorr | output | 1 | Error detected, not repaired |
| out_loc | output | 2 | Field of repaired bit: 0 data, 1 row, 2 column, 3 corner |
| out_row | output | max(1,clog2(ROWS)) | Row of repaired bit |
| out_col | output | max(1,clog2(COLS)) | Column of repaired bit |

## Verification
The riskiest cases are the ones that look like single errors but are not. A row check bit flipped together with a column check bit gives one failing row and one failing column, the same as a data error. A data bit flipped together with the corner looks similar as well. A design that skips the corner test would "fix" a good data bit in these cases. The bench also flips each parity field alone, because a design that misreads those would corrupt the data or report the wrong field. The bench checks the stall path as well, where a design without a hold would drop or overwrite a result. Random words with zero, one or two flips at random positions are compared against a bench-side encoder and a bench-side model of where each flip was placed.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    localparam logic MODE_ENCODE = 1'b0;
    localparam logic MODE_DECODE = 1'b1;

    localparam logic [1:0] LOC_DATA   = 2'd0;
    localparam logic [1:0] LOC_ROWCHK = 2'd1;
    localparam logic [1:0] LOC_COLCHK = 2'd2;
    localparam logic [1:0] LOC_CORNER = 2'd3;

    typedef enum logic [2:0] {
        VERD_CLEAN    = 3'd0,
        VERD_FIX_DATA = 3'd1,
        VERD_FIX_ROW  = 3'd2,
        VERD_FIX_COL  = 3'd3,
        VERD_FIX_CRN  = 3'd4,
        VERD_UNCORR   = 3'd5
    } verdict_e;

endpackage

// File: rtl/tdp_parity_gen.sv
// Row, column and whole-word even parity of a row-major data grid.
module tdp_parity_gen #(
    parameter  int ROWS = 4,
    parameter  int COLS = 8,
    localparam int DW   = ROWS * COLS
) (
    input  logic [DW-1:0]   data,
    output logic [ROWS-1:0] row_par,
    output logic [COLS-1:0] col_par,
    output logic            all_par
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_par[r] = ^data[r*COLS +: COLS];
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] column_bits;
        for (genvar r = 0; r < ROWS; r++) begin : g_pick
            assign column_bits[r] = data[r*COLS + c];
        end
        assign col_par[c] = ^column_bits;
    end

    assign all_par = ^data;

endmodule

// File: rtl/tdp_syndrome.sv
// Compares locally generated parities with the received check vector.
module tdp_syndrome #(
    parameter  int ROWS = 4,
    parameter  int COLS = 8,
    localparam int KW   = ROWS + COLS + 1
) (
    input  logic [ROWS-1:0] gen_row,
    input  logic [COLS-1:0] gen_col,
    input  logic            gen_all,
    input  logic [KW-1:0]   rx_chk,
    output logic [ROWS-1:0] row_syn,
    output logic [COLS-1:0] col_syn,
    output logic            all_syn,
    output logic            rowchk_syn,
    output logic            colchk_syn
);

    logic [ROWS-1:0] rx_row;
    logic [COLS-1:0] rx_col;
    logic            rx_crn;

    assign rx_row = rx_chk[ROWS-1:0];
    assign rx_col = rx_chk[ROWS+COLS-1:ROWS];
    assign rx_crn = rx_chk[KW-1];

    assign row_syn = gen_row ^ rx_row;
    assign col_syn = gen_col ^ rx_col;
    assign all_syn = gen_all ^ rx_crn;

    // The received row bits and column bits must each agree with the corner.
    assign rowchk_syn = (^rx_row) ^ rx_crn;
    assign colchk_syn = (^rx_col) ^ rx_crn;

endmodule

// File: rtl/tdp_locator.sv
// Classifies a syndrome and builds the flip masks for a single-bit repair.
module tdp_locator
    import tdp_pkg::*;
#(
    parameter  int ROWS = 4,
    parameter  int COLS = 8,
    localparam int DW   = ROWS * COLS,
    localparam int KW   = ROWS + COLS + 1,
    localparam int RIW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CIW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [ROWS-1:0] row_syn,
    input  logic [COLS-1:0] col_syn,
    input  logic            all_syn,
    input  logic            rowchk_syn,
    input  logic            colchk_syn,
    output verdict_e        verdict,
    output logic [RIW-1:0]  hit_row,
    output logic [CIW-1:0]  hit_col,
    output logic [DW-1:0]   data_flip,
    output logic [KW-1:0]   chk_flip
);

    logic           row_none, row_single;
    logic           col_none, col_single;
    logic [RIW-1:0] row_pos;
    logic [CIW-1:0] col_pos;
    logic           fix_data, fix_row, fix_col, fix_crn;

    assign row_none   = (row_syn == '0);
    assign col_none   = (col_syn == '0);
    assign row_single = !row_none && ((row_syn & (row_syn - 1'b1)) == '0);
    assign col_single = !col_none && ((col_syn & (col_syn - 1'b1)) == '0);

    always_comb begin
        row_pos = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_syn[r]) row_pos = RIW'(r);
        end
    end

    always_comb begin
        col_pos = '0;
        for (int c = 0; c < COLS; c++) begin
            if (col_syn[c]) col_pos = CIW'(c);
        end
    end

    always_comb begin
        if (row_none && col_none && !all_syn && !rowchk_syn && !colchk_syn)
            verdict = VERD_CLEAN;
        else if (row_single && col_single && all_syn && !rowchk_syn && !colchk_syn)
            verdict = VERD_FIX_DATA;
        else if (row_single && col_none && !all_syn && rowchk_syn && !colchk_syn)
            verdict = VERD_FIX_ROW;
        else if (row_none && col_single && !all_syn && !rowchk_syn && colchk_syn)
            verdict = VERD_FIX_COL;
        else if (row_none && col_none && all_syn && rowchk_syn && colchk_syn)
            verdict = VERD_FIX_CRN;
        else
            verdict = VERD_UNCORR;
    end

    assign fix_data = (verdict == VERD_FIX_DATA);
    assign fix_row  = (verdict == VERD_FIX_ROW);
    assign fix_col  = (verdict == VERD_FIX_COL);
    assign fix_crn  = (verdict == VERD_FIX_CRN);

    for (genvar r = 0; r < ROWS; r++) begin : g_flip_r
        for (genvar c = 0; c < COLS; c++) begin : g_flip_c
            assign data_flip[r*COLS + c] = fix_data & row_syn[r] & col_syn[c];
        end
    end

    assign chk_flip = {fix_crn,
                       col_syn & {COLS{fix_col}},
                       row_syn & {ROWS{fix_row}}};

    assign hit_row = (fix_data || fix_row) ? row_pos : '0;
    assign hit_col = (fix_data || fix_col) ? col_pos : '0;

endmodule

// File: rtl/tdp_corrector.sv
// Two-dimensional even-parity encoder / single-error corrector.
module tdp_corrector
    import tdp_pkg::*;
#(
    parameter  int ROWS = 4,
    parameter  int COLS = 8,
    localparam int DW   = ROWS * COLS,
    localparam int KW   = ROWS + COLS + 1,
    localparam int RIW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CIW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic           in_mode,
    input  logic [DW-1:0]  in_data,
    input  logic [KW-1:0]  in_chk,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [DW-1:0]  out_data,
    output logic [KW-1:0]  out_chk,
    output logic           out_corrected,
    output logic           out_uncorr,
    output logic [1:0]     out_loc,
    output logic [RIW-1:0] out_row,
    output logic [CIW-1:0] out_col
);

    typedef struct packed {
        logic           valid;
        logic [DW-1:0]  data;
        logic [KW-1:0]  chk;
        logic           corrected;
        logic           uncorr;
        logic [1:0]     loc;
        logic [RIW-1:0] row;
        logic [CIW-1:0] col;
    } stage_t;

    stage_t st_d, st_q;

    logic [ROWS-1:0] gen_row, row_syn;
    logic [COLS-1:0] gen_col, col_syn;
    logic            gen_all, all_syn, rowchk_syn, colchk_syn;
    verdict_e        verdict;
    logic [RIW-1:0]  hit_row;
    logic [CIW-1:0]  hit_col;
    logic [DW-1:0]   data_flip;
    logic [KW-1:0]   chk_flip;
    logic            accept;

    tdp_parity_gen #(.ROWS(ROWS), .COLS(COLS)) u_gen (
        .data    (in_data),
        .row_par (gen_row),
        .col_par (gen_col),
        .all_par (gen_all)
    );

    tdp_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
        .gen_row    (gen_row),
        .gen_col    (gen_col),
        .gen_all    (gen_all),
        .rx_chk     (in_chk),
        .row_syn    (row_syn),
        .col_syn    (col_syn),
        .all_syn    (all_syn),
        .rowchk_syn (rowchk_syn),
        .colchk_syn (colchk_syn)
    );

    tdp_locator #(.ROWS(ROWS), .COLS(COLS)) u_loc (
        .row_syn    (row_syn),
        .col_syn    (col_syn),
        .all_syn    (all_syn),
        .rowchk_syn (rowchk_syn),
        .colchk_syn (colchk_syn),
        .verdict    (verdict),
        .hit_row    (hit_row),
        .hit_col    (hit_col),
        .data_flip  (data_flip),
        .chk_flip   (chk_flip)
    );

    assign in_ready = !st_q.valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (out_ready) st_d.valid = 1'b0;
        if (accept) begin
            st_d.valid = 1'b1;
            if (in_mode == MODE_ENCODE) begin
                st_d.data      = in_data;
                st_d.chk       = {gen_all, gen_col, gen_row};
                st_d.corrected = 1'b0;
                st_d.uncorr    = 1'b0;
                st_d.loc       = LOC_DATA;
                st_d.row       = '0;
                st_d.col       = '0;
            end else begin
                st_d.data      = in_data ^ data_flip;
                st_d.chk       = in_chk ^ chk_flip;
                st_d.corrected = (verdict != VERD_CLEAN) && (verdict != VERD_UNCORR);
                st_d.uncorr    = (verdict == VERD_UNCORR);
                st_d.row       = hit_row;
                st_d.col       = hit_col;
                case (verdict)
                    VERD_FIX_ROW: st_d.loc = LOC_ROWCHK;
                    VERD_FIX_COL: st_d.loc = LOC_COLCHK;
                    VERD_FIX_CRN: st_d.loc = LOC_CORNER;
                    default:      st_d.loc = LOC_DATA;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign out_data      = st_q.data;
    assign out_chk       = st_q.chk;
    assign out_corrected = st_q.corrected;
    assign out_uncorr    = st_q.uncorr;
    assign out_loc       = st_q.loc;
    assign out_row       = st_q.row;
    assign out_col       = st_q.col;

endmodule

// File: rtl/tdp_corrector_chk.sv
module tdp_corrector_chk #(
    parameter  int ROWS = 4,
    parameter  int COLS = 8,
    localparam int DW   = ROWS * COLS,
    localparam int KW   = ROWS + COLS + 1,
    localparam int RIW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CIW  = (COLS > 1) ? $clog2(COLS) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic           in_mode,
    input logic [DW-1:0]  in_data,
    input logic [KW-1:0]  in_chk,
    input logic           out_valid,
    input logic           out_ready,
    input logic [DW-1:0]  out_data,
    input logic [KW-1:0]  out_chk,
    input logic           out_corrected,
    input logic           out_uncorr,
    input logic [1:0]     out_loc,
    input logic [RIW-1:0] out_row,
    input logic [CIW-1:0] out_col
);

    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_corrected && out_uncorr));

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chk)));

    assert_encode_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_mode) |=>
            (!out_corrected && !out_uncorr && out_data == $past(in_data)));

    assert_encode_corner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_mode) |=>
            ((^out_data) == out_chk[KW-1] && (^out_chk[ROWS-1:0]) == out_chk[KW-1]));

    assert_fix_consistent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_corrected) |->
            ((^out_data) == out_chk[KW-1] &&
             (^out_chk[ROWS-1:0]) == out_chk[KW-1] &&
             (^out_chk[ROWS+COLS-1:ROWS]) == out_chk[KW-1]));

    assert_one_data_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode) |=>
            (!(out_corrected && out_loc == 2'd0) ||
             $countones(out_data ^ $past(in_data)) == 1));

    assert_uncorr_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_mode) |=>
            (!out_uncorr || (out_data == $past(in_data) && out_chk == $past(in_chk) &&
                             out_row == '0 && out_col == '0)));

endmodule

bind tdp_corrector tdp_corrector_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .in_mode       (in_mode),
    .in_data       (in_data),
    .in_chk        (in_chk),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_chk       (out_chk),
    .out_corrected (out_corrected),
    .out_uncorr    (out_uncorr),
    .out_loc       (out_loc),
    .out_row       (out_row),
    .out_col       (out_col)
);

// File: tb/sim_tdp_corrector.sv
`timescale 1ns/1ps
module sim_tdp_corrector;

    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int DW   = ROWS * COLS;
    localparam int KW   = ROWS + COLS + 1;
    localparam int NB   = DW + KW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_mode;
    logic [DW-1:0] in_data;
    logic [KW-1:0] in_chk;
    logic          out_valid, out_ready;
    logic [DW-1:0] out_data;
    logic [KW-1:0] out_chk;
    logic          out_corrected, out_uncorr;
    logic [1:0]    out_loc;
    logic [1:0]    out_row;
    logic [2:0]    out_col;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    tdp_corrector #(.ROWS(ROWS), .COLS(COLS)) u0 (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_mode (in_mode),
        .in_data (in_data), .in_chk (in_chk),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_data (out_data), .out_chk (out_chk),
        .out_corrected (out_corrected), .out_uncorr (out_uncorr),
        .out_loc (out_loc), .out_row (out_row), .out_col (out_col)
    );

    function automatic logic [KW-1:0] ref_chk(input logic [DW-1:0] d);
        logic [KW-1:0] k = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (d[r*COLS + c]) begin
                    k[r]        = ~k[r];
                    k[ROWS + c] = ~k[ROWS + c];
                    k[KW-1]     = ~k[KW-1];
                end
        return k;
    endfunction

    function automatic logic [63:0] pk(input logic v, input logic [DW-1:0] d,
                                       input logic [KW-1:0] k, input logic cr,
                                       input logic un, input logic [1:0] lc,
                                       input logic [1:0] rw, input logic [2:0] cl);
        return {9'd0, v, d, k, cr, un, lc, rw, cl};
    endfunction

    task automatic expect_eq(input string req, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] outs();
        return pk(out_valid, out_data, out_chk, out_corrected, out_uncorr,
                  out_loc, out_row, out_col);
    endfunction

    // Drive one word; returns at the negedge right after acceptance.
    task automatic send(input logic m, input logic [DW-1:0] d, input logic [KW-1:0] k);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_data = d; in_chk = k;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic flip(inout logic [DW-1:0] d, inout logic [KW-1:0] k, input int p);
        if (p < DW) d[p] = ~d[p];
        else        k[p-DW] = ~k[p-DW];
    endtask

    task automatic single_case(input string req, input logic [DW-1:0] d, input int p);
        logic [DW-1:0] rd = d;
        logic [KW-1:0] k  = ref_chk(d);
        logic [KW-1:0] rk = k;
        logic [1:0] lc; logic [1:0] rw; logic [2:0] cl;
        int q;
        flip(rd, rk, p);
        q = p - DW;
        if (p < DW)               begin lc = 2'd0; rw = 2'(p / COLS); cl = 3'(p % COLS); end
        else if (q < ROWS)        begin lc = 2'd1; rw = 2'(q); cl = 3'd0; end
        else if (q < ROWS + COLS) begin lc = 2'd2; rw = 2'd0; cl = 3'(q - ROWS); end
        else                      begin lc = 2'd3; rw = 2'd0; cl = 3'd0; end
        send(1'b1, rd, rk);
        expect_eq(req, "single flip repair", outs(), pk(1'b1, d, k, 1'b1, 1'b0, lc, rw, cl));
    endtask

    task automatic double_case(input string req, input logic [DW-1:0] d, input int p1, input int p2);
        logic [DW-1:0] rd = d;
        logic [KW-1:0] rk = ref_chk(d);
        flip(rd, rk, p1);
        flip(rd, rk, p2);
        send(1'b1, rd, rk);
        expect_eq(req, "double flip detect", outs(), pk(1'b1, rd, rk, 1'b0, 1'b1, 2'd0, 2'd0, 3'd0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R9 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [DW-1:0] a_data;
        int p1, p2, ne;
        void'($urandom(32'd2024));
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0;
        in_data = '0; in_chk = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        expect_eq("R11", "reset outputs", {outs()[62:0], in_ready},
                  {pk(1'b0, '0, '0, 1'b0, 1'b0, 2'd0, 2'd0, 3'd0)[62:0], 1'b1});

        // R1: bit (1,2) sets row 1, column 2 and corner
        send(1'b0, DW'(1) << (1*COLS + 2), '0);
        expect_eq("R1", "layout", 64'(out_chk), 64'((1 << 1) | (1 << 6) | (1 << 12)));
        // R2: all ones gives all-zero check bits
        send(1'b0, '1, '1);
        expect_eq("R2", "encode ones", outs(), pk(1'b1, '1, '0, 1'b0, 1'b0, 2'd0, 2'd0, 3'd0));
        // R9: output drops after the next edge with no new word
        @(negedge clk);
        expect_eq("R9", "valid drop", 64'(out_valid), 64'd0);
        // R3: clean decode
        d = 32'hA5C3_0F96;
        send(1'b1, d, ref_chk(d));
        expect_eq("R3", "clean pass", outs(), pk(1'b1, d, ref_chk(d), 1'b0, 1'b0, 2'd0, 2'd0, 3'd0));
        // R4..R7 directed single flips
        single_case("R4", 32'h1234_5678, 2*COLS + 5);
        single_case("R5", 32'hFFFF_0000, DW + 3);
        single_case("R6", 32'h0F0F_F0F0, DW + ROWS + 7);
        single_case("R7", '0, DW + KW - 1);
        // R8 directed doubles that mimic single-error syndromes
        double_case("R8", 32'h8421_1248, DW + 2, DW + ROWS + 4);
        double_case("R8", 32'h0000_0001, 9, DW + KW - 1);
        double_case("R8", 32'hDEAD_BEEF, 3, 6);
        double_case("R8", 32'h0, 0, 8);

        // R10: hold while stalled
        @(negedge clk);
        out_ready = 1'b0;
        a_data = 32'h5555_AAAA;
        in_valid = 1'b1; in_mode = 1'b1; in_data = a_data; in_chk = ref_chk(a_data);
        @(posedge clk);
        @(negedge clk);
        in_data = 32'h0BAD_F00D; in_chk = ref_chk(32'h0BAD_F00D);
        expect_eq("R10", "ready low in stall", 64'(in_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        expect_eq("R10", "held output", outs(),
                  pk(1'b1, a_data, ref_chk(a_data), 1'b0, 1'b0, 2'd0, 2'd0, 3'd0));
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        expect_eq("R10", "next after stall", outs(),
                  pk(1'b1, 32'h0BAD_F00D, ref_chk(32'h0BAD_F00D), 1'b0, 1'b0, 2'd0, 2'd0, 3'd0));

        // Random mix
        for (int i = 0; i < 400; i++) begin
            d = $urandom;
            if ($urandom % 4 == 0) begin
                send(1'b0, d, 13'($urandom));
                expect_eq("R2", "random encode", outs(),
                          pk(1'b1, d, ref_chk(d), 1'b0, 1'b0, 2'd0, 2'd0, 3'd0));
            end else begin
                ne = $urandom % 3;
                p1 = $urandom % NB;
                p2 = (p1 + 1 + ($urandom % (NB - 1))) % NB;
                if (ne == 0) begin
                    send(1'b1, d, ref_chk(d));
                    expect_eq("R3", "random clean", outs(),
                              pk(1'b1, d, ref_chk(d), 1'b0, 1'b0, 2'd0, 2'd0, 3'd0));
                end else if (ne == 1) begin
                    single_case(p1 < DW ? "R4" : "R5", d, p1);
                end else begin
                    double_case("R8", d, p1, p2);
                end
            end
            expect_eq("R12", "flags exclusive", 64'(out_corrected & out_uncorr), 64'd0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule